// File: doc/BRIEF.md
# Page Translation Buffer with Write Permission and Dirty Tracking

This block is a small fully associative cache of virtual-to-physical page translations. A 32-bit byte virtual address is split into a 20-bit virtual page number and a 12-bit page offset. On a hit, the stored 18-bit physical page number is joined to the untouched offset to form a 30-bit physical address, all in the same cycle as the lookup. On a miss, the block raises a refill request so that a page-table walker outside the block can fetch the translation before the data access goes ahead.

Each entry keeps a read-only flag and a dirty flag. A store that hits a read-only page raises a protection fault and does not complete. A store that hits any other page marks its entry dirty. Refills arrive on a separate port. When a refill displaces a live entry, the block reports that entry's page numbers and dirty flag in the refill cycle, so that write-back of the page can be decided from them. A flush input, or reset, invalidates every entry at once.

Top module: `page_xlate_buf`

## Requirements
- R1: On a hit, `lk_paddr` equals the entry's 18-bit physical page number in bits 29:12, and `lk_vaddr[11:0]` passed through unchanged in bits 11:0.
- R2: A lookup hits only when some valid entry's tag equals `lk_vaddr[31:12]`. The hit result is combinational and appears in the cycle the lookup is presented.
- R3: When `lk_valid` is 1 and no entry hits, `lk_refill_req` is 1, `lk_hit` is 0 and `lk_paddr` is zero.
- R4: `lk_prot_fault` is 1 exactly when `lk_valid`, `lk_write` and a hit on an entry with the read-only flag set are all true. Such a store leaves that entry's dirty flag unchanged.
- R5: A store (`lk_write`=1) that hits an entry without the read-only flag sets that entry's dirty flag at the next clock edge. A read (`lk_write`=0) never sets it.
- R6: A refill (`fill_valid`=1, `flush`=0) is written at the next clock edge as a valid, clean entry holding `fill_vpn`, `fill_ppn` and `fill_ro`. It wins over a same-cycle store to the slot it replaces.
- R7: The refill slot is chosen as follows:
  - It is the lowest-index invalid entry if one exists.
  - Otherwise it is the slot held by a round-robin pointer. The pointer is 0 after reset and advances by one, modulo 8, each time a refill uses it.
- R8: In a refill cycle, `evict_valid` is 1 exactly when the chosen slot holds a valid entry. `evict_dirty`, `evict_vpn` and `evict_ppn` then give that entry's dirty flag and page numbers.
- R9: `flush` clears every valid bit at the next edge. A refill in the same cycle is dropped: no eviction is reported and the pointer does not move. Reset does the same and also sets the pointer to 0.
- R10: With `lk_valid` at 0, `lk_hit`, `lk_refill_req` and `lk_prot_fault` are all 0, and no dirty flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries at the next edge |
| lk_valid | input | 1 | Lookup request present |
| lk_write | input | 1 | Lookup is a store |
| lk_vaddr | input | 32 | Virtual byte address |
| lk_paddr | output | 30 | Translated physical byte address (zero on a miss) |
| lk_hit | output | 1 | Translation found |
| lk_refill_req | output | 1 | Translation missing; a page-table access is needed |
| lk_prot_fault | output | 1 | Store to a read-only page |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Virtual page number of the new entry |
| fill_ppn | input | 18 | Physical page number of the new entry |
| fill_ro | input | 1 | Read-only flag of the new entry |
| evict_valid | output | 1 | The refill displaces a valid entry |
| evict_dirty | output | 1 | Dirty flag of the displaced entry |
| evict_vpn | output | 20 | Virtual page number of the displaced entry |
| evict_ppn | output | 18 | Physical page number of the displaced entry |

## Verification
The bench aims at the following corner cases:
- **Read-only store.** A store to a read-only page that hits must fault without dirtying the entry. A design that dirtied it would later report a clean page as needing write-back.
- **Victim choice.** Refills must prefer a hole over the round-robin slot. A design that ignored holes after a flush would evict live entries and report spurious evictions. A pointer that advanced on hole fills would pick the wrong slot once the buffer is full again.
- **Same-cycle collisions.** A store that hits the very slot being refilled must leave the new entry clean. A flush that coincides with a refill must drop the refill. Either mistake shows up as a wrong dirty report or a stale hit later on.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int unsigned VA_W    = 32;
    localparam int unsigned OFF_W   = 12;
    localparam int unsigned PPN_W   = 18;
    localparam int unsigned VPN_W   = VA_W - OFF_W;
    localparam int unsigned PA_W    = PPN_W + OFF_W;
    localparam int unsigned NUM_ENT = 8;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [OFF_W-1:0] off_t;
    typedef logic [PA_W-1:0]  paddr_t;

    typedef struct packed {
        logic valid;
        logic ro;
        logic dirty;
        vpn_t vpn;
        ppn_t ppn;
    } xlate_ent_t;

    function automatic vpn_t page_of(input logic [VA_W-1:0] va);
        return va[VA_W-1:OFF_W];
    endfunction

    function automatic off_t offset_of(input logic [VA_W-1:0] va);
        return va[OFF_W-1:0];
    endfunction

    function automatic paddr_t join_paddr(input ppn_t p, input off_t o);
        return {p, o};
    endfunction
endpackage

// File: rtl/xlate_store.sv
module xlate_store
    import xlate_pkg::*;
#(
    parameter int unsigned ENTRIES = NUM_ENT,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  vpn_t                   wr_vpn,
    input  ppn_t                   wr_ppn,
    input  logic                   wr_ro,
    input  logic [ENTRIES-1:0]     set_dirty,
    output xlate_ent_t [ENTRIES-1:0] ents
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                ents[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ents[i].valid <= 1'b1;
                ents[i].ro    <= wr_ro;
                ents[i].dirty <= 1'b0;
                ents[i].vpn   <= wr_vpn;
                ents[i].ppn   <= wr_ppn;
            end else if (set_dirty[i]) begin
                ents[i].dirty <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlate_match.sv
module xlate_match
    import xlate_pkg::*;
#(
    parameter int unsigned ENTRIES = NUM_ENT,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  xlate_ent_t [ENTRIES-1:0] ents,
    input  vpn_t                     vpn,
    output logic [ENTRIES-1:0]       hit_vec,
    output logic                     any_hit,
    output logic [IDX_W-1:0]         hit_idx
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = ents[i].valid && (ents[i].vpn == vpn);
    end

    assign any_hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xlate_victim.sv
module xlate_victim
    import xlate_pkg::*;
#(
    parameter int unsigned ENTRIES = NUM_ENT,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               take,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] hole_idx;
    logic             hole_found;

    always_comb begin
        hole_found = 1'b0;
        hole_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                hole_found = 1'b1;
                hole_idx   = IDX_W'(i);
            end
        end
    end

    assign victim_idx = hole_found ? hole_idx : ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (take && !hole_found) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/page_xlate_buf.sv
module page_xlate_buf
    import xlate_pkg::*;
#(
    parameter int unsigned ENTRIES = NUM_ENT,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic [PA_W-1:0]   lk_paddr,
    output logic              lk_hit,
    output logic              lk_refill_req,
    output logic              lk_prot_fault,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_ro,
    output logic              evict_valid,
    output logic              evict_dirty,
    output logic [VPN_W-1:0]  evict_vpn,
    output logic [PPN_W-1:0]  evict_ppn
);
    xlate_ent_t [ENTRIES-1:0] ents;
    logic [ENTRIES-1:0]       hit_vec;
    logic [ENTRIES-1:0]       valid_vec;
    logic [ENTRIES-1:0]       set_dirty;
    logic                     any_hit;
    logic [IDX_W-1:0]         hit_idx;
    logic [IDX_W-1:0]         victim_idx;
    logic                     fill_take;
    xlate_ent_t               hit_ent;
    xlate_ent_t               vic_ent;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_flags
        assign valid_vec[i] = ents[i].valid;
        assign set_dirty[i] = lk_valid && lk_write && hit_vec[i] && !ents[i].ro;
    end

    assign fill_take = fill_valid && !flush;

    xlate_match #(.ENTRIES(ENTRIES)) u_match (
        .ents    (ents),
        .vpn     (page_of(lk_vaddr)),
        .hit_vec (hit_vec),
        .any_hit (any_hit),
        .hit_idx (hit_idx)
    );

    xlate_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .valid_vec  (valid_vec),
        .take       (fill_take),
        .victim_idx (victim_idx)
    );

    xlate_store #(.ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .wr_en     (fill_take),
        .wr_idx    (victim_idx),
        .wr_vpn    (fill_vpn),
        .wr_ppn    (fill_ppn),
        .wr_ro     (fill_ro),
        .set_dirty (set_dirty),
        .ents      (ents)
    );

    assign hit_ent = ents[hit_idx];
    assign vic_ent = ents[victim_idx];

    assign lk_hit        = lk_valid && any_hit;
    assign lk_refill_req = lk_valid && !any_hit;
    assign lk_prot_fault = lk_hit && lk_write && hit_ent.ro;
    assign lk_paddr      = lk_hit ? join_paddr(hit_ent.ppn, offset_of(lk_vaddr)) : '0;

    assign evict_valid = fill_take && vic_ent.valid;
    assign evict_dirty = evict_valid && vic_ent.dirty;
    assign evict_vpn   = evict_valid ? vic_ent.vpn : '0;
    assign evict_ppn   = evict_valid ? vic_ent.ppn : '0;
endmodule

// File: rtl/page_xlate_buf_chk.sv
module page_xlate_buf_chk
    import xlate_pkg::*;
#(
    parameter int unsigned ENTRIES = NUM_ENT
) (
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic               lk_valid,
    input logic               lk_write,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic [PA_W-1:0]    lk_paddr,
    input logic               lk_hit,
    input logic               lk_refill_req,
    input logic               lk_prot_fault,
    input logic               fill_valid,
    input logic               evict_valid,
    input logic [ENTRIES-1:0] valid_vec
);
    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    assert_hit_or_refill_R3: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> (lk_hit ^ lk_refill_req));

    assert_miss_zero_addr_R3: assert property (@(posedge clk) disable iff (rst)
        lk_refill_req |-> (lk_paddr == '0));

    assert_fault_store_hit_R4: assert property (@(posedge clk) disable iff (rst)
        lk_prot_fault |-> (lk_hit && lk_write));

    assert_fill_sets_valid_R6: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !flush) |=> (valid_vec != '0));

    assert_evict_in_fill_R8: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> (fill_valid && !flush));

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !(lk_hit || lk_refill_req || lk_prot_fault));
endmodule

bind page_xlate_buf page_xlate_buf_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .lk_valid      (lk_valid),
    .lk_write      (lk_write),
    .lk_vaddr      (lk_vaddr),
    .lk_paddr      (lk_paddr),
    .lk_hit        (lk_hit),
    .lk_refill_req (lk_refill_req),
    .lk_prot_fault (lk_prot_fault),
    .fill_valid    (fill_valid),
    .evict_valid   (evict_valid),
    .valid_vec     (valid_vec)
);

// File: tb/page_xlate_buf_tb.sv
module page_xlate_buf_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst, flush, lk_valid, lk_write, fill_valid, fill_ro;
    logic [31:0] lk_vaddr;
    logic [29:0] lk_paddr;
    logic        lk_hit, lk_refill_req, lk_prot_fault;
    logic [19:0] fill_vpn, evict_vpn;
    logic [17:0] fill_ppn, evict_ppn;
    logic        evict_valid, evict_dirty;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit m_valid [N];
    bit m_ro    [N];
    bit m_dirty [N];
    int m_vpn   [N];
    int m_ppn   [N];
    int m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_xlate_buf u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
        .lk_paddr(lk_paddr), .lk_hit(lk_hit), .lk_refill_req(lk_refill_req),
        .lk_prot_fault(lk_prot_fault),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_ro(fill_ro), .evict_valid(evict_valid), .evict_dirty(evict_dirty),
        .evict_vpn(evict_vpn), .evict_ppn(evict_ppn)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_ro[i] = 0; m_dirty[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
        end
        m_ptr = 0;
    endfunction

    function automatic bit model_has(input int vpn);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == vpn) return 1;
        return 0;
    endfunction

    // one cycle: drive, check combinational outputs, clock, update model
    task automatic step(input bit lv, input bit lw, input logic [31:0] va,
                        input bit fv, input int fvpn, input int fppn, input bit fro,
                        input bit fl, input string ctx);
        int hidx, vic;
        bit hole;
        lk_valid = lv; lk_write = lw; lk_vaddr = va;
        fill_valid = fv; fill_vpn = fvpn[19:0]; fill_ppn = fppn[17:0]; fill_ro = fro;
        flush = fl;
        #1;
        hidx = -1;
        for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == int'(va[31:12])) hidx = i;
        vic = -1; hole = 0;
        for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) begin vic = i; hole = 1; end
        if (!hole) vic = m_ptr;
        // R2 R10: hit only on valid matching tag, and only with a request
        check({"R2 R10 ", ctx}, "hit", lk_hit, lv && hidx >= 0);
        check({"R3 R10 ", ctx}, "refill_req", lk_refill_req, lv && hidx < 0);
        check({"R4 ", ctx}, "prot_fault", lk_prot_fault, lv && lw && hidx >= 0 && m_ro[hidx]);
        check({"R1 R3 ", ctx}, "paddr", lk_paddr,
              (lv && hidx >= 0) ? ((longint'(m_ppn[hidx]) << 12) | va[11:0]) : 0);
        check({"R8 R9 ", ctx}, "evict_valid", evict_valid, fv && !fl && m_valid[vic]);
        if (fv && !fl && m_valid[vic]) begin
            check({"R5 R7 R8 ", ctx}, "evict_dirty", evict_dirty, m_dirty[vic]);
            check({"R7 R8 ", ctx}, "evict_vpn", evict_vpn, m_vpn[vic]);
            check({"R7 R8 ", ctx}, "evict_ppn", evict_ppn, m_ppn[vic]);
        end
        @(posedge clk);
        if (fl) begin
            for (int i = 0; i < N; i++) m_valid[i] = 0;
        end else begin
            if (lv && lw && hidx >= 0 && !m_ro[hidx]) m_dirty[hidx] = 1;
            if (fv) begin
                m_valid[vic] = 1; m_ro[vic] = fro; m_dirty[vic] = 0;
                m_vpn[vic] = fvpn; m_ppn[vic] = fppn;
                if (!hole) m_ptr = (m_ptr + 1) % N;
            end
        end
        @(negedge clk);
    endtask

    task automatic look(input bit lw, input int vpn, input int off, input string ctx);
        step(1, lw, {vpn[19:0], off[11:0]}, 0, 0, 0, 0, 0, ctx);
    endtask

    task automatic fill(input int vpn, input int ppn, input bit ro, input string ctx);
        step(0, 0, 32'h0, 1, vpn, ppn, ro, 0, ctx);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; flush = 0; lk_valid = 0; lk_write = 0; lk_vaddr = '0;
        fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_ro = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R9: after reset every lookup misses
        look(0, 20'h00000, 12'h000, "reset state");
        look(1, 20'hfffff, 12'hfff, "reset state");
        // R6 R7: fill all holes in index order
        for (int i = 0; i < N; i++) fill(32'h100 + i, 32'h20000 + i * 7, (i % 3) == 0, "fill holes");
        // R1 R2: read every entry with varied offsets
        for (int i = 0; i < N; i++) look(0, 32'h100 + i, i * 12'h1a5, "read hits");
        look(0, 32'h1ff, 12'h123, "tag mismatch");
        // R4 R5: store to each entry; read-only ones fault
        for (int i = 0; i < N; i++) look(1, 32'h100 + i, 12'h004, "stores");
        // R10: no request, fill untouched
        step(0, 1, {20'h101, 12'h0}, 0, 0, 0, 0, 0, "idle");
        // R7 R8: full buffer, pointer at 0 (slot 0 read-only, clean)
        fill(32'h300, 32'h3aaaa, 0, "evict slot0 clean");
        fill(32'h301, 32'h3bbbb, 0, "evict slot1 dirty");
        // R6: store hits slot 2 while refill replaces slot 2 -> new entry clean
        step(1, 1, {20'h102, 12'h0}, 1, 32'h302, 32'h3cccc, 0, 0, "store vs refill");
        fill(32'h303, 32'h3dddd, 1, "evict slot3 ro");
        // R9: flush with fill drops fill
        step(0, 0, 32'h0, 1, 32'h399, 32'h1, 0, 1, "flush with fill");
        look(0, 32'h399, 0, "after flush");
        look(0, 32'h300, 0, "after flush");
        // R7: holes preferred over pointer after flush
        for (int i = 0; i < N; i++) fill(32'h400 + i, 32'h10 + i, i[0], "refill after flush");
        fill(32'h500, 32'h55, 0, "pointer resumes");
        // mixed traffic
        for (int k = 0; k < 600; k++) begin
            int r, vpn;
            r = int'($urandom % 100);
            vpn = 32'h600 + int'($urandom % 14);
            if (r < 3) step(0, 0, 32'h0, 0, 0, 0, 0, 1, "mixed flush");
            else if (r < 35 && !model_has(vpn))
                step($urandom % 2, $urandom % 2, {20'(32'h600 + ($urandom % 14)), 12'($urandom)},
                     1, vpn, int'($urandom % 32'h40000), $urandom % 2, 0, "mixed fill");
            else step($urandom % 8 != 0, $urandom % 2, {vpn[19:0], 12'($urandom)},
                      0, 0, 0, 0, 0, "mixed lookup");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule